// File: doc/BRIEF.md
# Three-Axis Sample Register Bank with Coherent Byte Reads

This block keeps the latest 16-bit sample of each of three axes, X, Y and Z, and serves them to a byte-wide register read port. The sensor datapath delivers a sample set with a single-cycle strobe. A host reads the bank one byte at a time through a read strobe and an 8-bit address. The read data follow the address combinationally. The effects of a read (flag clears, pair locking) take place at the clock edge where the strobe is high.

Each axis is handled by a pair slot. The slot runs a three-state machine: `PAIR_OPEN` (the slot updates freely), `PAIR_LO_TAKEN` (the low data byte was read first) and `PAIR_HI_TAKEN` (the high data byte was read first). With block update enabled, a read of one byte moves `PAIR_OPEN` to the matching taken state. A read of the other byte, or block update being switched off, returns the slot to `PAIR_OPEN`. While a slot is taken, arriving samples wait in a shadow register. The shadow is copied into the visible register on the edge where the slot reopens, unless a newer sample arrives on that same edge, in which case the newer sample is stored instead. The bank also keeps a data-available flag and an overrun flag for each axis, builds a status byte from them and drives a data-ready line. It can exchange the two bytes of every axis in the address map.

Top module: `accel_sample_regbank`

## Requirements
- R1: Data bytes sit at 28h..2Dh, two per axis in the order X, Y, Z, and the status byte sits at 27h. A read of any other address returns 00h and changes no state.
- R2: With `swap_bytes` low, the lower address of each axis returns data bits 7:0 and the upper address returns bits 15:8. With `swap_bytes` high, the two are exchanged: X = 15E0h reads E0h then 15h unswapped, and 15h then E0h swapped.
- R3: `data_ready` is high in the cycle after a sample strobe with at least one axis enabled. It stays high until the high data byte of every enabled axis has been read.
- R4: The status byte is {ZYXOR, ZOR, YOR, XOR, ZYXDA, ZDA, YDA, XDA}, MSB first. An axis's DA bit is set by a sample strobe while that axis is enabled and is cleared by a read of that axis's high data byte; a low-byte read leaves it set. ZYXDA is the OR of the DA bits of the enabled axes. Reading the status byte changes nothing.
- R5: An axis's overrun bit is set when a sample strobe arrives for that enabled axis while its DA bit is set and its high byte is not being read in that cycle. ZYXOR is the OR of the overrun bits of the enabled axes.
- R6: An axis's overrun bit clears by itself when its high data byte is read and no new sample arrives in that cycle.
- R7: With `bdu_en` high, once one byte of an axis has been read, that axis returns its held sample until its other byte has been read. A sample that arrives meanwhile becomes visible after the pair is released. Other axes keep updating.
- R8: With `bdu_en` low, every sample strobe updates all three axes at once, even between the two byte reads of a pair.
- R9: An axis whose enable bit (`axis_en` bit 0 = X, bit 1 = Y, bit 2 = Z) is low stores the value zero on a sample strobe and does not set its DA bit.
- R10: After reset, all data bytes read 00h, the status byte is 00h and `data_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | New sample set strobe, one cycle |
| smp_x | input | 16 | X sample, two's complement, left justified |
| smp_y | input | 16 | Y sample |
| smp_z | input | 16 | Z sample |
| axis_en | input | 3 | Axis enables, bit 0 = X, bit 1 = Y, bit 2 = Z |
| bdu_en | input | 1 | Block update of an axis pair between its two byte reads |
| swap_bytes | input | 1 | Exchange the two bytes of each axis in the map |
| rd_en | input | 1 | Read strobe; its effects apply at the clock edge |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read byte for `rd_addr` |
| status | output | 8 | Status byte, same value as address 27h |
| data_ready | output | 1 | New sample set waiting to be read |

## Verification
The assertions assume that `axis_en`, `bdu_en` and `swap_bytes` are quasi-static configuration bits. The read-clear and data-ready properties excuse a cycle in which the enables change, because a change of enables alone moves the ZYX summary bits. They also assume at most one byte is read per cycle, which the single address makes true. The bench changes configuration only while no read or sample is in flight. It issues each read and each sample strobe on its own cycle, so every expected flag and byte follows from one event at a time.

// File: rtl/accel_rb_pkg.sv
package accel_rb_pkg;
    localparam int AXES   = 3;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PAIR_OPEN     = 2'd0,
        PAIR_LO_TAKEN = 2'd1,
        PAIR_HI_TAKEN = 2'd2
    } pair_state_e;
endpackage

// File: rtl/axis_pair_slot.sv
module axis_pair_slot
    import accel_rb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic              axis_on,
    input  logic [DATA_W-1:0] smp_val,
    input  logic              bdu_en,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [DATA_W-1:0] held_val,
    output logic              da_flag,
    output logic              ovr_flag
);
    pair_state_e       st_q, st_d;
    logic [DATA_W-1:0] shadow_q;
    logic              pend_q;
    logic              lock_d;
    logic [DATA_W-1:0] store_val;

    assign store_val = axis_on ? smp_val : '0;
    assign lock_d    = (st_d != PAIR_OPEN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PAIR_OPEN;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PAIR_OPEN: begin
                if (bdu_en && rd_lo)      st_d = PAIR_LO_TAKEN;
                else if (bdu_en && rd_hi) st_d = PAIR_HI_TAKEN;
            end
            PAIR_LO_TAKEN: if (!bdu_en || rd_hi) st_d = PAIR_OPEN;
            PAIR_HI_TAKEN: if (!bdu_en || rd_lo) st_d = PAIR_OPEN;
            default:       st_d = PAIR_OPEN;
        endcase
    end

    // outputs: visible value, shadow and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_val <= '0;
            shadow_q <= '0;
            pend_q   <= 1'b0;
            da_flag  <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            if (smp_vld) begin
                if (lock_d) begin
                    shadow_q <= store_val;
                    pend_q   <= 1'b1;
                end else begin
                    held_val <= store_val;
                    pend_q   <= 1'b0;
                end
            end else if (pend_q && !lock_d) begin
                held_val <= shadow_q;
                pend_q   <= 1'b0;
            end

            if (smp_vld && axis_on) begin
                da_flag  <= 1'b1;
                ovr_flag <= ovr_flag | (da_flag & ~rd_hi);
            end else if (rd_hi) begin
                da_flag  <= 1'b0;
                ovr_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/regbank_read_mux.sv
module regbank_read_mux
    import accel_rb_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 8,
    parameter int          STAT_W    = 8,
    parameter logic [7:0]  DATA_BASE = 8'h28,
    parameter logic [7:0]  STAT_ADDR = 8'h27
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              swap_bytes,
    input  logic [DATA_W-1:0] axis_val [AXES],
    input  logic [STAT_W-1:0] status,
    output logic [BYTE_W-1:0] rd_data,
    output logic [AXES-1:0]   rd_lo,
    output logic [AXES-1:0]   rd_hi
);
    logic [AXES-1:0]   sel_even, sel_odd;
    logic [BYTE_W-1:0] axis_byte [AXES];

    for (genvar i = 0; i < AXES; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] EVEN_A = ADDR_W'(DATA_BASE) + ADDR_W'(2 * i);
        localparam logic [ADDR_W-1:0] ODD_A  = EVEN_A + ADDR_W'(1);
        assign sel_even[i] = (rd_addr == EVEN_A);
        assign sel_odd[i]  = (rd_addr == ODD_A);
        assign rd_hi[i] = rd_en & ((sel_odd[i] & ~swap_bytes) | (sel_even[i] & swap_bytes));
        assign rd_lo[i] = rd_en & ((sel_even[i] & ~swap_bytes) | (sel_odd[i] & swap_bytes));
        assign axis_byte[i] = ((sel_odd[i] & ~swap_bytes) | (sel_even[i] & swap_bytes))
                              ? axis_val[i][DATA_W-1 -: BYTE_W]
                              : axis_val[i][BYTE_W-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(STAT_ADDR)) rd_data = BYTE_W'(status);
        for (int i = 0; i < AXES; i++) begin
            if (sel_even[i] || sel_odd[i]) rd_data = axis_byte[i];
        end
    end
endmodule

// File: rtl/accel_sample_regbank.sv
module accel_sample_regbank
    import accel_rb_pkg::*;
#(
    parameter int         DATA_W    = 16,
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] DATA_BASE = 8'h28,
    parameter logic [7:0] STAT_ADDR = 8'h27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_x,
    input  logic [DATA_W-1:0] smp_y,
    input  logic [DATA_W-1:0] smp_z,
    input  logic [2:0]        axis_en,
    input  logic              bdu_en,
    input  logic              swap_bytes,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        status,
    output logic              data_ready
);
    localparam int STAT_W = 2 * AXES + 2;

    logic [DATA_W-1:0] smp_in   [AXES];
    logic [DATA_W-1:0] axis_val [AXES];
    logic [AXES-1:0]   da_vec, ovr_vec, rd_lo, rd_hi;
    logic [STAT_W-1:0] status_w;

    assign smp_in[0] = smp_x;
    assign smp_in[1] = smp_y;
    assign smp_in[2] = smp_z;

    for (genvar i = 0; i < AXES; i++) begin : g_slot
        axis_pair_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_vld  (smp_vld),
            .axis_on  (axis_en[i]),
            .smp_val  (smp_in[i]),
            .bdu_en   (bdu_en),
            .rd_lo    (rd_lo[i]),
            .rd_hi    (rd_hi[i]),
            .held_val (axis_val[i]),
            .da_flag  (da_vec[i]),
            .ovr_flag (ovr_vec[i])
        );
    end

    assign status_w = {|(ovr_vec & axis_en), ovr_vec, |(da_vec & axis_en), da_vec};
    assign status   = 8'(status_w);
    assign data_ready = |(da_vec & axis_en);

    regbank_read_mux #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .STAT_W    (STAT_W),
        .DATA_BASE (DATA_BASE),
        .STAT_ADDR (STAT_ADDR)
    ) u_rdmux (
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .swap_bytes (swap_bytes),
        .axis_val   (axis_val),
        .status     (status_w),
        .rd_data    (rd_data),
        .rd_lo      (rd_lo),
        .rd_hi      (rd_hi)
    );
endmodule

// File: rtl/accel_regbank_chk.sv
module accel_regbank_chk #(
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] DATA_BASE = 8'h28,
    parameter logic [7:0] STAT_ADDR = 8'h27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic [2:0]        axis_en,
    input logic              swap_bytes,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [7:0]        status,
    input logic              data_ready
);
    logic addr_mapped;
    assign addr_mapped = (rd_addr == ADDR_W'(STAT_ADDR)) ||
                         ((rd_addr >= ADDR_W'(DATA_BASE)) &&
                          (rd_addr <  ADDR_W'(DATA_BASE) + ADDR_W'(6)));

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mapped |-> rd_data == 8'h00); // R1

    AST_DRDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && (|axis_en)) |=> (data_ready || axis_en != $past(axis_en))); // R3

    AST_HIGH_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !smp_vld && !swap_bytes && rd_addr == ADDR_W'(DATA_BASE) + ADDR_W'(1))
        |=> !status[0]); // R4

    AST_STATUS_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !smp_vld && rd_addr == ADDR_W'(STAT_ADDR))
        |=> (status == $past(status) || axis_en != $past(axis_en))); // R4

    AST_OVR_NEEDS_DA: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] |-> status[0]); // R5
endmodule

bind accel_sample_regbank accel_regbank_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_BASE (DATA_BASE),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld    (smp_vld),
    .axis_en    (axis_en),
    .swap_bytes (swap_bytes),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .status     (status),
    .data_ready (data_ready)
);

// File: tb/accel_sample_regbank_test.sv
module accel_sample_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic [2:0]  axis_en = 3'b111;
    logic        bdu_en = 1'b0;
    logic        swap_bytes = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data, status;
    logic        data_ready;

    int checks = 0;
    int errors = 0;
    logic [7:0] got;

    always #2.5 clk = ~clk;

    accel_sample_regbank uut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .axis_en(axis_en), .bdu_en(bdu_en), .swap_bytes(swap_bytes),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .status(status), .data_ready(data_ready)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
        @(negedge clk);
        smp_x = x; smp_y = y; smp_z = z; smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
    endtask

    task automatic drain();
        logic [7:0] dummy;
        bdu_en = 1'b0; swap_bytes = 1'b0; axis_en = 3'b111;
        rd(8'h29, dummy); rd(8'h2B, dummy); rd(8'h2D, dummy);
    endtask

    task automatic t_reset();
        for (int a = 8'h28; a <= 8'h2D; a++) begin
            rd(8'(a), got); check("R10 data byte after reset", got, 8'h00);
        end
        check("R10 status after reset", status, 8'h00);
        check("R10 data_ready after reset", {7'b0, data_ready}, 8'h00);
    endtask

    task automatic t_byte_order();
        drain();
        push(16'h15E0, 16'h4000, 16'hEA20);
        rd(8'h28, got); check("R2 X low unswapped", got, 8'hE0);
        rd(8'h29, got); check("R2 X high unswapped", got, 8'h15);
        rd(8'h2C, got); check("R2 Z low unswapped", got, 8'h20);
        swap_bytes = 1'b1;
        rd(8'h28, got); check("R2 X swapped at 28h", got, 8'h15);
        rd(8'h29, got); check("R2 X swapped at 29h", got, 8'hE0);
        rd(8'h2A, got); check("R2 Y swapped at 2Ah", got, 8'h40);
        swap_bytes = 1'b0;
    endtask

    task automatic t_ready_flags();
        drain();
        push(16'h0102, 16'h0304, 16'h0506);
        check("R3 data_ready after sample", {7'b0, data_ready}, 8'h01);
        check("R4 status after sample", status, 8'h0F);
        rd(8'h29, got);
        check("R4 XDA cleared by high read", status, 8'h0E);
        rd(8'h2B, got);
        check("R4 YDA cleared", status, 8'h0C);
        rd(8'h2C, got);
        check("R4 low read keeps ZDA", status, 8'h0C);
        check("R3 data_ready held until last high", {7'b0, data_ready}, 8'h01);
        rd(8'h2D, got);
        check("R3 data_ready falls", {7'b0, data_ready}, 8'h00);
        check("R4 status empty", status, 8'h00);
    endtask

    task automatic t_overrun();
        drain();
        push(16'h1111, 16'h2222, 16'h3333);
        push(16'h4444, 16'h5555, 16'h6666);
        check("R5 overrun on all axes", status, 8'hFF);
        rd(8'h29, got);
        check("R6 XOR clears on X high read", status, 8'hEE);
        rd(8'h2B, got); rd(8'h2D, got);
        check("R6 all overrun cleared", status, 8'h00);
        push(16'h0, 16'h0, 16'h0);
        check("R5 no overrun after read data", status, 8'h0F);
    endtask

    task automatic t_block_update();
        drain();
        bdu_en = 1'b1;
        push(16'h1111, 16'hAAAA, 16'h3344);
        rd(8'h28, got); check("R7 X low first", got, 8'h11);
        rd(8'h2D, got); check("R7 Z high first", got, 8'h33);
        push(16'h2222, 16'hBBBB, 16'h5566);
        rd(8'h2A, got); check("R7 open Y updated", got, 8'hBB);
        rd(8'h2B, got); check("R7 Y pair consistent", got, 8'hBB);
        rd(8'h29, got); check("R7 X high from held sample", got, 8'h11);
        rd(8'h2C, got); check("R7 Z low from held sample", got, 8'h44);
        rd(8'h28, got); check("R7 X shadow loaded low", got, 8'h22);
        rd(8'h29, got); check("R7 X shadow loaded high", got, 8'h22);
        rd(8'h2D, got); check("R7 Z shadow loaded high", got, 8'h55);
        rd(8'h2C, got); check("R7 Z shadow loaded low", got, 8'h66);
        bdu_en = 1'b0;
    endtask

    task automatic t_no_block();
        drain();
        push(16'h1111, 16'h0, 16'h0);
        rd(8'h28, got); check("R8 X low", got, 8'h11);
        push(16'h2222, 16'h0, 16'h0);
        rd(8'h29, got); check("R8 X high from newer sample", got, 8'h22);
    endtask

    task automatic t_disabled();
        drain();
        axis_en = 3'b001;
        push(16'h1234, 16'h5678, 16'h9ABC);
        check("R9 only XDA set", status, 8'h09);
        rd(8'h2B, got); check("R9 disabled Y stores zero", got, 8'h00);
        rd(8'h2C, got); check("R9 disabled Z stores zero", got, 8'h00);
        check("R3 data_ready waits for enabled X", {7'b0, data_ready}, 8'h01);
        rd(8'h29, got); check("R9 enabled X kept", got, 8'h12);
        check("R3 data_ready falls with only X enabled", {7'b0, data_ready}, 8'h00);
        axis_en = 3'b111;
    endtask

    task automatic t_unmapped();
        drain();
        push(16'hAAAA, 16'hBBBB, 16'hCCCC);
        rd(8'h30, got); check("R1 unmapped 30h reads zero", got, 8'h00);
        rd(8'h26, got); check("R1 unmapped 26h reads zero", got, 8'h00);
        rd(8'h27, got); check("R1 status at 27h untouched", got, 8'h0F);
        rd(8'h27, got); check("R4 status read has no effect", got, 8'h0F);
        check("R1 data_ready untouched", {7'b0, data_ready}, 8'h01);
        rd(8'h2D, got); check("R1 Z data untouched", got, 8'hCC);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_byte_order();
        t_ready_flags();
        t_overrun();
        t_block_update();
        t_no_block();
        t_disabled();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule